// File: doc/BRIEF.md
# Indirect Register Front End for an I/O Interrupt Controller

This block is the register-access side of an I/O interrupt controller. Software reaches every internal register through two bus locations. A selector register chooses a register, and a data window then reads or writes the register it names. Behind the window are an identification register, a read-only version word and a table of 48 routing entries. Each routing entry is 64 bits wide and is reached as two 32-bit halves.

The bus side is a simple 32-bit port. A request carries an operation code and a byte count. A transaction is accepted in one cycle, executed in the next, and answered with a one-cycle response pulse that carries read data and an error flag. Requests of the wrong width, and codes that are neither read nor write, are refused with the error flag and change no state.

The delivery side gets the whole table as a flat vector. It returns two signals: a strobe per entry that sets the entry's remote-IRR bit, and a live delivery-status level per entry. The block sends back a one-cycle strobe for each entry whose remote-IRR bit is cleared by software.

A small state machine sequences every transaction. It has three states:
- **ST_IDLE**: the port is ready. It moves to ST_EXEC when a request is seen.
- **ST_EXEC**: the access is decoded and performed. It always moves to ST_RESP.
- **ST_RESP**: the response is presented. It always returns to ST_IDLE.

Top module: `ioic_regfront`

## Requirements
- R1: A request is accepted only when `bus_op` is read (2'b01) or write (2'b10) and `bus_size` is 4 (bytes). Any other request gets a response with `bus_err`=1 and `bus_rdata`=0, and it leaves the selector, the ID register and every entry unchanged.
- R2: A write to offset 0x00 stores `bus_wdata[7:0]` as the selector. A read of offset 0x00 returns the selector zero-extended to 32 bits.
- R3: A read of any offset other than 0x00 and 0x10 returns 0xFFFFFFFF with `bus_err`=0. A write to such an offset changes nothing.
- R4: A window access (offset 0x10) whose selector is not 0x00, 0x01, 0x02 or in 0x10..0x6F reads 0, and a write to it changes nothing.
- R5: Entry n is reached through selector 0x10+2n for bits 31:0 and 0x11+2n for bits 63:32. It appears on `rte_flat[64n+63:64n]`.
- R6: Selector 0x01 reads 0x002F0011: version code 0x11 in bits 7:0 and the highest entry index, 47, in bits 23:16. Writes to it are ignored.
- R7: A window write with selector 0x00 updates only ID bits 27:24. Selectors 0x00 and 0x02 both read the ID with all other bits 0. Writes to selector 0x02 are ignored.
- R8: Bits 14 (remote IRR) and 12 (delivery status) of an entry's lower half are not writable. Bit 14 is set by a `rirr_set[n]` pulse. Bit 12 takes `dlv_stat[n]` one clock later.
- R9: A write to an entry's lower half with bit 15 (trigger mode) = 0 clears bit 14. If bit 14 was set, `rirr_clr[n]` pulses for the response cycle. This write wins over a `rirr_set[n]` pulse in the same cycle.
- R10: After reset every entry is 0x0001000000010000 (bit 16, the mask, set), the selector is 0, the ID is 0, `bus_ready`=1 and `bus_rsp_valid`=0.
- R11: A request is taken only while `bus_ready` is high. `bus_ready` drops for two cycles. `bus_rsp_valid` is high for exactly the second of them, and the access takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Request strobe |
| bus_op | input | 2 | 01 read, 10 write, others invalid |
| bus_size | input | 3 | Access size in bytes |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Port idle, request may be issued |
| bus_rsp_valid | output | 1 | Response pulse |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Request refused |
| rirr_set | input | 48 | Per-entry remote-IRR set pulse |
| dlv_stat | input | 48 | Per-entry delivery-status level |
| rte_flat | output | 3072 | All entries, entry n at bits 64n+63:64n |
| rirr_clr | output | 48 | Per-entry remote-IRR clear strobe |

## Verification
The bench attacks the read-only bits by writing data with bits 14 and 12 inverted while those bits are set. A design that masks the wrong positions would let software forge or erase a pending level interrupt. It writes an edge-trigger value both to entries with remote IRR set and to entries with it clear. A design that pulses the clear strobe without a pending bit, or that never clears the bit, shows up in the per-clock comparison of `rte_flat` and `rirr_clr`. The bench also targets the selector edges 0x0F, 0x6F and 0x70, the parity of the half select, and refused requests of the wrong size or code. Those requests must leave every register untouched; an off-by-one range check or a missing size check would corrupt an entry or the selector.

// File: rtl/ioic_pkg.sv
package ioic_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } ioic_state_e;

    localparam logic [1:0] OP_READ  = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b10;

    typedef struct packed {
        logic        ok;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
    } ioic_cmd_t;
endpackage

// File: rtl/ioic_bus_fsm.sv
module ioic_bus_fsm
    import ioic_pkg::*;
#(
    parameter int SZW       = 3,
    parameter int FULL_SIZE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [1:0]      op,
    input  logic [SZW-1:0]  size,
    input  logic [7:0]      addr,
    input  logic [31:0]     wdata,
    input  logic [31:0]     rd_value,
    output logic            ready,
    output logic            exec,
    output ioic_cmd_t       cmd,
    output logic            rsp_valid,
    output logic [31:0]     rdata,
    output logic            err
);
    ioic_state_e st_q, st_nx;
    logic [31:0] rdata_q;
    logic        err_q;
    logic        req_ok;

    assign req_ok = ((op == OP_READ) || (op == OP_WRITE)) && (size == SZW'(FULL_SIZE));

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (req) st_nx = ST_EXEC;
            ST_EXEC: st_nx = ST_RESP;
            ST_RESP: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd     <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && req) begin
                cmd.ok    <= req_ok;
                cmd.wr    <= (op == OP_WRITE);
                cmd.addr  <= addr;
                cmd.wdata <= wdata;
            end
            if (st_q == ST_EXEC) begin
                err_q   <= !cmd.ok;
                rdata_q <= (cmd.ok && !cmd.wr) ? rd_value : 32'd0;
            end
        end
    end

    always_comb begin
        ready     = (st_q == ST_IDLE);
        exec      = (st_q == ST_EXEC);
        rsp_valid = (st_q == ST_RESP);
        rdata     = rsp_valid ? rdata_q : 32'd0;
        err       = rsp_valid & err_q;
    end
endmodule

// File: rtl/ioic_sel_regs.sv
module ioic_sel_regs #(
    parameter int SEL_W = 8,
    parameter int ID_LO = 24,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic             id_we,
    input  logic [31:0]      wdata,
    output logic [SEL_W-1:0] sel_q,
    output logic [31:0]      id_word
);
    logic [ID_W-1:0] id_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (sel_we) sel_q <= wdata[SEL_W-1:0];
            if (id_we)  id_q  <= wdata[ID_LO +: ID_W];
        end
    end

    always_comb begin
        id_word = 32'd0;
        id_word[ID_LO +: ID_W] = id_q;
    end
endmodule

// File: rtl/ioic_rte_bank.sv
module ioic_rte_bank #(
    parameter int          NUM_RTE = 48,
    parameter logic [63:0] RTE_RST = 64'h0001_0000_0001_0000,
    parameter int          RIRR_B  = 14,
    parameter int          DSTS_B  = 12,
    parameter int          TRIG_B  = 15,
    localparam int         EW      = $clog2(NUM_RTE)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [EW-1:0]          wr_idx,
    input  logic                   wr_hi,
    input  logic [31:0]            wdata,
    input  logic [EW-1:0]          rd_idx,
    input  logic                   rd_hi,
    output logic [31:0]            rd_data,
    input  logic [NUM_RTE-1:0]     rirr_set,
    input  logic [NUM_RTE-1:0]     dlv_stat,
    output logic [64*NUM_RTE-1:0]  rte_flat,
    output logic [NUM_RTE-1:0]     rirr_clr
);
    logic [63:0] ent [NUM_RTE];

    for (genvar i = 0; i < NUM_RTE; i++) begin : g_ent
        logic hit;
        assign hit = we && (wr_idx == EW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[i]      <= RTE_RST;
                rirr_clr[i] <= 1'b0;
            end else begin
                rirr_clr[i]       <= 1'b0;
                ent[i][DSTS_B]    <= dlv_stat[i];
                if (rirr_set[i]) ent[i][RIRR_B] <= 1'b1;
                if (hit) begin
                    if (wr_hi) begin
                        ent[i][63:32] <= wdata;
                    end else begin
                        ent[i][31:RIRR_B+1]   <= wdata[31:RIRR_B+1];
                        ent[i][RIRR_B-1:DSTS_B+1] <= wdata[RIRR_B-1:DSTS_B+1];
                        ent[i][DSTS_B-1:0]    <= wdata[DSTS_B-1:0];
                        if (!wdata[TRIG_B]) begin
                            ent[i][RIRR_B] <= 1'b0;
                            rirr_clr[i]    <= ent[i][RIRR_B] | rirr_set[i];
                        end
                    end
                end
            end
        end

        assign rte_flat[64*i +: 64] = ent[i];
    end

    always_comb begin
        rd_data = 32'd0;
        if (32'(rd_idx) < NUM_RTE)
            rd_data = rd_hi ? ent[rd_idx][63:32] : ent[rd_idx][31:0];
    end
endmodule

// File: rtl/ioic_regfront.sv
module ioic_regfront
    import ioic_pkg::*;
#(
    parameter int          NUM_RTE  = 48,
    parameter logic [7:0]  VER_CODE = 8'h11,
    parameter logic [7:0]  SEL_OFF  = 8'h00,
    parameter logic [7:0]  WIN_OFF  = 8'h10,
    parameter logic [7:0]  RTE_BASE = 8'h10,
    parameter logic [63:0] RTE_RST  = 64'h0001_0000_0001_0000,
    localparam int         EW       = $clog2(NUM_RTE),
    localparam int         RTE_LIM  = 32'(RTE_BASE) + 2*NUM_RTE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req,
    input  logic [1:0]             bus_op,
    input  logic [2:0]             bus_size,
    input  logic [7:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic                   bus_ready,
    output logic                   bus_rsp_valid,
    output logic [31:0]            bus_rdata,
    output logic                   bus_err,
    input  logic [NUM_RTE-1:0]     rirr_set,
    input  logic [NUM_RTE-1:0]     dlv_stat,
    output logic [64*NUM_RTE-1:0]  rte_flat,
    output logic [NUM_RTE-1:0]     rirr_clr
);
    localparam logic [7:0]  SEL_ID   = 8'h00;
    localparam logic [7:0]  SEL_VER  = 8'h01;
    localparam logic [7:0]  SEL_ARB  = 8'h02;
    localparam logic [31:0] VER_WORD = {8'd0, 8'(NUM_RTE-1), 8'd0, VER_CODE};

    ioic_cmd_t   cmd;
    logic        exec;
    logic [31:0] rd_value;
    logic [7:0]  sel_q;
    logic [31:0] id_word;
    logic        is_sel, is_win, wr_go;
    logic        sel_is_rte;
    logic [7:0]  rel;
    logic [EW-1:0] ent_idx;
    logic [31:0] rte_rd;

    ioic_bus_fsm #(.SZW(3), .FULL_SIZE(4)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .op       (bus_op),
        .size     (bus_size),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rd_value (rd_value),
        .ready    (bus_ready),
        .exec     (exec),
        .cmd      (cmd),
        .rsp_valid(bus_rsp_valid),
        .rdata    (bus_rdata),
        .err      (bus_err)
    );

    always_comb begin
        is_sel     = (cmd.addr == SEL_OFF);
        is_win     = (cmd.addr == WIN_OFF);
        wr_go      = exec && cmd.ok && cmd.wr;
        sel_is_rte = (sel_q >= RTE_BASE) && (32'(sel_q) < RTE_LIM);
        rel        = sel_q - RTE_BASE;
        ent_idx    = rel[EW:1];
    end

    ioic_sel_regs #(.SEL_W(8), .ID_LO(24), .ID_W(4)) u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_we (wr_go && is_sel),
        .id_we  (wr_go && is_win && (sel_q == SEL_ID)),
        .wdata  (cmd.wdata),
        .sel_q  (sel_q),
        .id_word(id_word)
    );

    ioic_rte_bank #(.NUM_RTE(NUM_RTE), .RTE_RST(RTE_RST)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_go && is_win && sel_is_rte),
        .wr_idx  (ent_idx),
        .wr_hi   (sel_q[0]),
        .wdata   (cmd.wdata),
        .rd_idx  (ent_idx),
        .rd_hi   (sel_q[0]),
        .rd_data (rte_rd),
        .rirr_set(rirr_set),
        .dlv_stat(dlv_stat),
        .rte_flat(rte_flat),
        .rirr_clr(rirr_clr)
    );

    always_comb begin
        if (is_sel) begin
            rd_value = {24'd0, sel_q};
        end else if (is_win) begin
            if (sel_q == SEL_ID || sel_q == SEL_ARB) rd_value = id_word;
            else if (sel_q == SEL_VER)               rd_value = VER_WORD;
            else if (sel_is_rte)                     rd_value = rte_rd;
            else                                     rd_value = 32'd0;
        end else begin
            rd_value = 32'hFFFF_FFFF;
        end
    end
endmodule

// File: rtl/ioic_regfront_chk.sv
module ioic_regfront_chk #(
    parameter int NUM_RTE = 48
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_ready,
    input logic                  bus_rsp_valid,
    input logic                  bus_err,
    input logic [31:0]           bus_rdata,
    input logic [NUM_RTE-1:0]    rirr_set,
    input logic [NUM_RTE-1:0]    dlv_stat,
    input logic [64*NUM_RTE-1:0] rte_flat,
    input logic [NUM_RTE-1:0]    rirr_clr
);
    a_r11_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rsp_valid |=> !bus_rsp_valid);

    a_r11_rsp_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rsp_valid |-> !bus_ready);

    a_r11_rsp_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rsp_valid |=> bus_ready);

    a_r1_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rsp_valid && bus_err) |-> (bus_rdata == 32'd0));

    for (genvar i = 0; i < NUM_RTE; i++) begin : g_chk
        a_r8_rirr_set: assert property (@(posedge clk) disable iff (!rst_n)
            rirr_set[i] |=> (rte_flat[64*i+14] || rirr_clr[i]));

        a_r8_dstat_follow: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (rte_flat[64*i+12] == $past(dlv_stat[i])));

        a_r9_clr_leaves_zero: assert property (@(posedge clk) disable iff (!rst_n)
            rirr_clr[i] |-> !rte_flat[64*i+14]);

        a_r9_fall_pulses: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(rte_flat[64*i+14]) |-> rirr_clr[i]);
    end
endmodule

bind ioic_regfront ioic_regfront_chk #(.NUM_RTE(NUM_RTE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_ready    (bus_ready),
    .bus_rsp_valid(bus_rsp_valid),
    .bus_err      (bus_err),
    .bus_rdata    (bus_rdata),
    .rirr_set     (rirr_set),
    .dlv_stat     (dlv_stat),
    .rte_flat     (rte_flat),
    .rirr_clr     (rirr_clr)
);

// File: tb/ioic_regfront_tb_top.sv
module ioic_regfront_tb_top;
    localparam int N = 48;
    localparam logic [63:0] RST_V = 64'h0001_0000_0001_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_req = 1'b0;
    logic [1:0]      bus_op = 2'b00;
    logic [2:0]      bus_size = 3'd0;
    logic [7:0]      bus_addr = 8'd0;
    logic [31:0]     bus_wdata = 32'd0;
    logic            bus_ready, bus_rsp_valid, bus_err;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    rirr_set = '0;
    logic [N-1:0]    dlv_stat = '0;
    logic [64*N-1:0] rte_flat;
    logic [N-1:0]    rirr_clr;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    logic [63:0] m_rte [N];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic [N-1:0] m_clr;

    always #2 clk = ~clk;

    ioic_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_op(bus_op),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rsp_valid(bus_rsp_valid),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .rirr_set(rirr_set),
        .dlv_stat(dlv_stat), .rte_flat(rte_flat), .rirr_clr(rirr_clr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-clock comparison of the table and clear strobes (R5, R8, R9, R10)
    always @(posedge clk) begin
        #1;
        if (cmp_en) begin
            bit bad;
            bad = 1'b0;
            for (int i = 0; i < N; i++) begin
                if (rte_flat[64*i +: 64] !== m_rte[i]) begin
                    bad = 1'b1;
                    $display("FAIL R5 entry %0d actual=%h expected=%h", i, rte_flat[64*i +: 64], m_rte[i]);
                end
            end
            if (rirr_clr !== m_clr) begin
                bad = 1'b1;
                $display("FAIL R9 rirr_clr actual=%h expected=%h", rirr_clr, m_clr);
            end
            checks++;
            if (bad) errors++;
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [7:0] s;
        s = m_sel;
        if (a == 8'h00) return {24'd0, m_sel};
        if (a != 8'h10) return 32'hFFFF_FFFF;
        if (s == 8'h00 || s == 8'h02) return {4'd0, m_id, 24'd0};
        if (s == 8'h01) return 32'h002F_0011;
        if (s >= 8'h10 && s <= 8'h6F) begin
            int n;
            n = (int'(s) - 16) / 2;
            return s[0] ? m_rte[n][63:32] : m_rte[n][31:0];
        end
        return 32'd0;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        if (a == 8'h00) begin
            m_sel = d[7:0];
        end else if (a == 8'h10) begin
            if (m_sel == 8'h00) m_id = d[27:24];
            else if (m_sel >= 8'h10 && m_sel <= 8'h6F) begin
                int n;
                logic [31:0] lo;
                n = (int'(m_sel) - 16) / 2;
                if (m_sel[0]) m_rte[n][63:32] = d;
                else begin
                    lo = d;
                    lo[12] = m_rte[n][12];
                    lo[14] = d[15] ? m_rte[n][14] : 1'b0;
                    if (!d[15] && m_rte[n][14]) m_clr[n] = 1'b1;
                    m_rte[n][31:0] = lo;
                end
            end
        end
    endtask

    // op/size/addr/data in, compares response with the model
    task automatic access(input string req, input logic [1:0] op, input logic [2:0] sz,
                          input logic [7:0] a, input logic [31:0] d);
        logic ok;
        logic [31:0] exp_d;
        ok = ((op == 2'b01) || (op == 2'b10)) && (sz == 3'd4);
        exp_d = (ok && op == 2'b01) ? exp_read(a) : 32'd0;
        @(negedge clk);
        chk("R11 ready before request", {63'd0, bus_ready}, 64'd1);
        bus_req = 1'b1; bus_op = op; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R11 busy during execute", {62'd0, bus_ready, bus_rsp_valid}, 64'd0);
        if (ok && op == 2'b10) model_write(a, d);
        @(negedge clk);
        chk("R11 response pulse", {63'd0, bus_rsp_valid}, 64'd1);
        chk({req, " data"}, {32'd0, bus_rdata}, {32'd0, exp_d});
        chk({req, " R1 error flag"}, {63'd0, bus_err}, {63'd0, !ok});
        m_clr = '0;
        @(negedge clk);
        chk("R11 response single cycle", {63'd0, bus_rsp_valid}, 64'd0);
    endtask

    task automatic rd(input string req, input logic [7:0] a);
        access(req, 2'b01, 3'd4, a, 32'd0);
    endtask
    task automatic wr(input string req, input logic [7:0] a, input logic [31:0] d);
        access(req, 2'b10, 3'd4, a, d);
    endtask
    task automatic sel(input logic [7:0] s);
        wr("R2 selector write", 8'h00, {24'hABCDEF, s});
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL R11 watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_rte[i] = RST_V;
        m_sel = 8'd0; m_id = 4'd0; m_clr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", {62'd0, bus_ready, bus_rsp_valid}, 64'd2);
        rd("R10 selector reset", 8'h00);
        rd("R10 ID reset", 8'h10);

        // R2 selector keeps low byte only
        wr("R2 wide selector", 8'h00, 32'h0001_2345);
        rd("R2 selector readback", 8'h00);

        // R6 version
        sel(8'h01); rd("R6 version", 8'h10);
        wr("R6 version write ignored", 8'h10, 32'h1234_5678);
        rd("R6 version unchanged", 8'h10);

        // R7 ID and arbitration
        sel(8'h00); wr("R7 ID write", 8'h10, 32'hFFFF_FFFF);
        rd("R7 ID bits 27:24", 8'h10);
        sel(8'h02); rd("R7 arbitration mirrors ID", 8'h10);
        wr("R7 arbitration write ignored", 8'h10, 32'h0000_0000);
        sel(8'h00); rd("R7 ID kept", 8'h10);
        wr("R7 ID write two", 8'h10, 32'hA5A5_A5A5);
        rd("R7 ID value two", 8'h10);

        // R1 refused requests
        access("R1 bad size read", 2'b01, 3'd2, 8'h00, 32'd0);
        access("R1 bad size selector write", 2'b10, 3'd1, 8'h00, 32'h0000_0033);
        access("R1 op 00", 2'b00, 3'd4, 8'h00, 32'h0000_0044);
        access("R1 op 11", 2'b11, 3'd4, 8'h00, 32'h0000_0055);
        rd("R1 selector untouched", 8'h00);
        sel(8'h10);
        access("R1 bad size window write", 2'b10, 3'd2, 8'h10, 32'h0000_0000);
        rd("R1 entry untouched", 8'h10);

        // R3 unknown offsets
        rd("R3 offset 04 read", 8'h04);
        rd("R3 offset 11 read", 8'h11);
        wr("R3 offset 04 write ignored", 8'h04, 32'h0000_0000);
        rd("R3 selector untouched", 8'h00);

        // R4 unknown selectors
        sel(8'h03); rd("R4 sel 03", 8'h10);
        sel(8'h0F); rd("R4 sel 0F", 8'h10);
        sel(8'h70); rd("R4 sel 70", 8'h10);
        wr("R4 sel 70 write ignored", 8'h10, 32'h0000_0000);
        sel(8'hFF); rd("R4 sel FF", 8'h10);

        // R5 halves and ends of table
        sel(8'h10); wr("R5 entry0 low", 8'h10, 32'h0000_A031);
        rd("R5 entry0 low read", 8'h10);
        sel(8'h11); wr("R5 entry0 high", 8'h10, 32'hFF00_0000);
        rd("R5 entry0 high read", 8'h10);
        sel(8'h6F); wr("R5 entry47 high", 8'h10, 32'h1200_0000);
        rd("R5 entry47 high read", 8'h10);
        sel(8'h6E); rd("R5 entry47 low read", 8'h10);
        sel(8'h1B); wr("R5 entry5 high", 8'h10, 32'h0300_0000);
        sel(8'h1A); wr("R5 entry5 low level", 8'h10, 32'h0000_8045);
        rd("R5 entry5 low read", 8'h10);

        // R8 read-only bits
        @(negedge clk);
        rirr_set[5] = 1'b1; m_rte[5][14] = 1'b1;
        dlv_stat[5] = 1'b1; m_rte[5][12] = 1'b1;
        @(negedge clk);
        rirr_set[5] = 1'b0;
        rd("R8 remote IRR visible", 8'h10);
        wr("R8 level write tries to clear ro bits", 8'h10, 32'h0000_8046);
        rd("R8 ro bits kept", 8'h10);
        @(negedge clk);
        dlv_stat[5] = 1'b0; m_rte[5][12] = 1'b0;
        @(negedge clk);
        wr("R8 write tries to set bit12", 8'h10, 32'h0000_D047);
        rd("R8 bit12 follows status input", 8'h10);

        // R9 edge write clears remote IRR and pulses strobe
        wr("R9 edge write clears", 8'h10, 32'h0000_0048);
        rd("R9 remote IRR cleared", 8'h10);
        wr("R9 edge write with nothing pending", 8'h10, 32'h0000_4049);
        sel(8'h6E);
        @(negedge clk);
        rirr_set[47] = 1'b1; m_rte[47][14] = 1'b1;
        @(negedge clk);
        rirr_set[47] = 1'b0;
        wr("R9 entry47 edge clears", 8'h10, 32'h0001_0050);
        rd("R9 entry47 read", 8'h10);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule